// File: doc/BRIEF.md
# Set/Way Cache Maintenance Sequencer

This block carries out clean, invalidate and clean-plus-invalidate maintenance on cache lines named by set and way. A single-line request takes its target from a 32-bit set/way word. The way sits in the top two bits. The set index sits above bit 5, and its width follows the configured cache size. Bit 0 routes the line to a tightly-coupled memory instead of the cache, and in that case the way field gives the memory number. A whole-cache request walks every set of way 0, then every set of way 1, and so on up to way 3. Each step sends one line command to the cache over a request/acknowledge port. A whole-cache walk never targets tightly-coupled memory.

The block also holds a cache-dirty flag. Any write hit sets it. A whole-cache operation clears it only when the operation runs to its end with no interrupt and with no write hit during its run. An interrupt stops a whole-cache walk after the line that is currently outstanding. The block then reports the walk as interrupted, and software restarts it, which begins again at way 0, set 0.

Top module: `setway_maint`

## Requirements
- R1: After reset no line request is raised, busy and done are 0, and the dirty status word reads 0.
- R2: A single-line operation (op_whole=0) issues exactly one request. Its way comes from word bits [31:30], its set from bits [cfg_size+6:5] (the cache has 2^(cfg_size+2) sets), and its memory-select flag from bit 0. All other bits are ignored. done pulses for one cycle after the acknowledge.
- R3: A whole-cache operation (op_whole=1) issues 4*2^(cfg_size+2) requests with line_tcm=0. Sets run from 0 upward within way 0, then ways 1, 2 and 3 follow. done pulses with line_intr=0 after the last acknowledge.
- R4: While line_req is high and line_ack is low, line_req, line_way, line_set, line_kind and line_tcm hold their values. No further line is requested before the current one is acknowledged.
- R5: The op_kind code is copied to line_kind: 1 = clean, 2 = invalidate, 3 = clean and invalidate. Kind 0 is ignored: no request is made and busy stays 0.
- R6: An op_start pulse while busy is ignored, and the running operation continues unchanged.
- R7: An irq during a whole-cache walk ends it at the next acknowledge, with done=1 and line_intr=1. An irq during a single-line operation has no effect, and that operation ends with line_intr=0.
- R8: A wr_hit pulse sets the dirty flag. The flag reads as bit 0 of dirty_word, and bits [31:1] are always 0.
- R9: The dirty flag clears only when a whole-cache operation of any kind completes without interruption. Single-line and interrupted operations leave it set.
- R10: A wr_hit during a whole-cache walk leaves the dirty flag set once that walk completes.
- R11: A whole-cache operation started after an interrupted one begins at way 0, set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | SIZE_W | Cache size code; number of sets is 2^(cfg_size+2) |
| op_start | input | 1 | Start pulse for an operation |
| op_kind | input | 2 | 1 clean, 2 invalidate, 3 clean and invalidate, 0 ignored |
| op_whole | input | 1 | 1 = walk entire cache, 0 = single line |
| op_word | input | 32 | Set/way word for single-line operations |
| irq | input | 1 | Interrupt; aborts a whole-cache walk |
| wr_hit | input | 1 | A write has hit the cache |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| line_intr | output | 1 | The last ended operation was cut short by irq |
| line_req | output | 1 | Line command request |
| line_kind | output | 2 | Maintenance kind of the requested line |
| line_way | output | 2 | Way (or memory number) of the requested line |
| line_set | output | SET_W | Set index of the requested line |
| line_tcm | output | 1 | Line targets tightly-coupled memory |
| line_ack | input | 1 | Line command accepted |
| dirty_word | output | 32 | Status word, bit 0 is the dirty flag |

## Verification
Single-line decoding is tried with words that set bits outside the set field for several size codes. This shows whether the mask follows cfg_size and whether bit 0 and bits [31:30] are routed to the right outputs. Whole-cache walks are run at two sizes, with both immediate and delayed acknowledges. These runs separate a correct set-major order from an off-by-one wrap and from a request that drifts while it waits. Interrupted walks, walks that see a write hit, and single-line operations on a dirty cache are each followed by a read of the dirty word. This shows which endings may clear the flag. A restart after an interrupt checks that the walk restarts from its first line instead of resuming.

// File: rtl/setway_maint.sv
module setway_maint #(
  parameter int SIZE_W = 3,
  localparam int SET_W = (1 << SIZE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              op_whole,
  input  logic [31:0]       op_word,
  input  logic              irq,
  input  logic              wr_hit,
  output logic              busy,
  output logic              done,
  output logic              line_intr,
  output logic              line_req,
  output logic [1:0]        line_kind,
  output logic [1:0]        line_way,
  output logic [SET_W-1:0]  line_set,
  output logic              line_tcm,
  input  logic              line_ack,
  output logic [31:0]       dirty_word
);

  logic             walk, abort_pend, taint, dirty;
  logic [SET_W-1:0] mask_in, mask_q, dec_set;
  logic             last_line, stop_now;
  logic             unused_ok;

  assign mask_in   = SET_W'((33'd1 << (32'(cfg_size) + 2)) - 33'd1);
  assign dec_set   = SET_W'(op_word >> 5) & mask_in;
  assign last_line = (line_way == 2'd3) && (line_set == mask_q);
  assign stop_now  = !walk || last_line || abort_pend || irq;
  assign busy      = line_req;
  assign dirty_word = {31'd0, dirty};
  assign unused_ok = &{1'b0, op_word[4:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_req   <= 1'b0;
      line_kind  <= 2'd0;
      line_way   <= 2'd0;
      line_set   <= '0;
      line_tcm   <= 1'b0;
      walk       <= 1'b0;
      abort_pend <= 1'b0;
      taint      <= 1'b0;
      mask_q     <= '0;
      done       <= 1'b0;
      line_intr  <= 1'b0;
      dirty      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wr_hit) dirty <= 1'b1;
      if (!line_req) begin
        if (op_start && op_kind != 2'd0) begin
          line_req   <= 1'b1;
          line_kind  <= op_kind;
          walk       <= op_whole;
          taint      <= wr_hit;
          abort_pend <= 1'b0;
          mask_q     <= mask_in;
          if (op_whole) begin
            line_way <= 2'd0;
            line_set <= '0;
            line_tcm <= 1'b0;
          end else begin
            line_way <= op_word[31:30];
            line_set <= dec_set;
            line_tcm <= op_word[0];
          end
        end
      end else begin
        if (walk && irq) abort_pend <= 1'b1;
        if (wr_hit) taint <= 1'b1;
        if (line_ack) begin
          if (stop_now) begin
            line_req  <= 1'b0;
            done      <= 1'b1;
            line_intr <= walk && !last_line && (abort_pend || irq);
            if (walk && last_line && !taint && !wr_hit) dirty <= 1'b0;
          end else if (line_set == mask_q) begin
            line_set <= '0;
            line_way <= line_way + 2'd1;
          end else begin
            line_set <= line_set + 1'b1;
          end
        end
      end
    end
  end

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && !line_ack |=> line_req && $stable(line_way) && $stable(line_set)
                              && $stable(line_kind) && $stable(line_tcm));

  a_r3_walk_no_tcm: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && walk |-> !line_tcm);

  a_r2_set_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (line_set & ~mask_q) == '0);

  a_r8_dirty_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty_word[0]) |-> $past(wr_hit));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_word[31:1] == 31'd0);

  a_r9_dirty_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dirty_word[0]) |-> done && !line_intr);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !line_req);

endmodule

// File: tb/setway_maint_tb.sv
module setway_maint_tb;
  localparam int SIZE_W = 3;
  localparam int SET_W  = (1 << SIZE_W) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic op_start = 0, op_whole = 0, irq = 0, wr_hit = 0, line_ack = 0;
  logic [1:0] op_kind = 0;
  logic [31:0] op_word = 0;
  logic busy, done, line_intr, line_req, line_tcm;
  logic [1:0] line_kind, line_way;
  logic [SET_W-1:0] line_set;
  logic [31:0] dirty_word;

  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  setway_maint #(.SIZE_W(SIZE_W)) u_dut (
    .clk, .rst_n, .cfg_size, .op_start, .op_kind, .op_whole, .op_word,
    .irq, .wr_hit, .busy, .done, .line_intr, .line_req, .line_kind,
    .line_way, .line_set, .line_tcm, .line_ack, .dirty_word);

  // {size[2:0], word[31:0], kind[1:0], way[1:0], set[8:0], tcm}
  localparam logic [48:0] VEC [6] = '{
    {3'd0, 32'hC000_0060, 2'd1, 2'd3, 9'd3,   1'b0},
    {3'd0, 32'h4000_0081, 2'd2, 2'd1, 9'd0,   1'b1},
    {3'd2, 32'h8000_01E0, 2'd3, 2'd2, 9'd15,  1'b0},
    {3'd7, 32'h0000_3FE1, 2'd1, 2'd0, 9'd511, 1'b1},
    {3'd3, 32'hFFFF_FFFE, 2'd2, 2'd3, 9'd31,  1'b0},
    {3'd1, 32'h4000_00A0, 2'd3, 2'd1, 9'd5,   1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] kind, input logic whole, input logic [31:0] word);
    @(negedge clk);
    op_start = 1; op_kind = kind; op_whole = whole; op_word = word;
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic ack_one();
    line_ack = 1;
    @(negedge clk);
    line_ack = 0;
  endtask

  // whole-cache walk; hold: delay on line 1; hit_at / poke_at: line index for wr_hit / stray start
  task automatic walk(input logic [2:0] sz, input logic [1:0] kind, input int hold,
                      input int hit_at, input int poke_at, input string tag);
    int n = 1 << (sz + 2);
    int idx = 0;
    logic bad = 0;
    logic [63:0] act = 0, exp = 0;
    cfg_size = sz;
    start(kind, 1'b1, 32'h0);
    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < n; s++) begin
        if (!bad && !(line_req === 1'b1 && line_way == w[1:0] && line_set == s[SET_W-1:0]
                      && line_kind == kind && line_tcm === 1'b0)) begin
          bad = 1;
          act = {line_req, line_tcm, line_kind, line_way, 7'd0, line_set};
          exp = {1'b1, 1'b0, kind, w[1:0], 7'd0, s[SET_W-1:0]};
        end
        if (idx == 1 && hold > 0) begin
          for (int h = 0; h < hold; h++) @(negedge clk);
          if (!bad && !(line_req === 1'b1 && line_way == 2'd0 && line_set == 1)) begin
            bad = 1; act = {line_req, 41'd0, line_way, 7'd0, line_set}; exp = 64'h1;
          end
        end
        if (idx == hit_at) begin wr_hit = 1; @(negedge clk); wr_hit = 0; end
        if (idx == poke_at) begin
          op_start = 1; op_kind = 2'd3; op_whole = 0; op_word = 32'hC000_0041;
          @(negedge clk); op_start = 0;
        end
        ack_one();
        idx++;
      end
    end
    check({tag, " walk order"}, act, exp);
    check({tag, " walk end done/intr/req"}, {done, line_intr, line_req}, {1'b1, 1'b0, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req/busy/done", {line_req, busy, done}, 3'b000);
    check("R1 dirty word", dirty_word, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R5 single-line decode table
    foreach (VEC[i]) begin
      logic [48:0] v = VEC[i];
      cfg_size = v[48:46];
      start(v[13:12], 1'b0, v[45:14]);
      check($sformatf("R2 R5 vec%0d fields", i),
            {line_req, line_kind, line_way, line_set, line_tcm},
            {1'b1, v[13:12], v[11:10], v[9:1], v[0]});
      ack_one();
      check($sformatf("R2 vec%0d done", i), {done, line_req, line_intr}, 3'b100);
      @(negedge clk);
      check($sformatf("R2 vec%0d done one cycle", i), done, 0);
    end

    // R5 kind 0 ignored
    start(2'd0, 1'b1, 32'h0);
    check("R5 kind0 no request", {line_req, busy}, 2'b00);
    @(negedge clk);
    check("R5 kind0 still idle", {line_req, busy, done}, 3'b000);

    // R3 R4 walk size 0 with delayed ack
    walk(3'd0, 2'd1, 3, -1, -1, "R3 R4 size0");
    check("R9 clean dirty stays 0", dirty_word, 0);

    // R8 write hit sets dirty
    @(negedge clk); wr_hit = 1; @(negedge clk); wr_hit = 0;
    check("R8 dirty word after hit", dirty_word, 32'h1);

    // R9 single line does not clear
    cfg_size = 3'd0;
    start(2'd3, 1'b0, 32'h0000_0020);
    ack_one();
    check("R9 single keeps dirty", dirty_word, 32'h1);

    // R3 R9 walk size 1, invalidate, clears dirty
    walk(3'd1, 2'd2, 0, -1, -1, "R3 size1");
    check("R9 whole invalidate clears dirty", dirty_word, 0);

    // R7 interrupted walk
    @(negedge clk); wr_hit = 1; @(negedge clk); wr_hit = 0;
    cfg_size = 3'd0;
    start(2'd3, 1'b1, 32'h0);
    for (int k = 0; k < 5; k++) ack_one();
    check("R7 sixth line position", {line_req, line_way, 7'd0, line_set}, {1'b1, 2'd1, 7'd0, 9'd1});
    irq = 1; @(negedge clk); irq = 0;
    check("R7 still waiting after irq", line_req, 1);
    ack_one();
    check("R7 interrupted end", {done, line_intr, line_req}, 3'b110);
    check("R9 interrupted keeps dirty", dirty_word, 32'h1);

    // R11 restart from beginning, completes, clears
    walk(3'd0, 2'd3, 0, -1, -1, "R11 restart");
    check("R11 restart clears dirty", dirty_word, 0);

    // R7 irq during single-line has no effect
    cfg_size = 3'd1;
    start(2'd1, 1'b0, 32'h8000_0040);
    irq = 1; @(negedge clk); irq = 0;
    ack_one();
    check("R7 single ignores irq", {done, line_intr}, 2'b10);

    // R10 write hit during walk; R6 stray start ignored
    walk(3'd0, 2'd1, 0, 4, 7, "R6 R10 walk");
    check("R10 dirty stays after tainted walk", dirty_word, 32'h1);
    @(negedge clk);
    check("R6 no leftover request", {line_req, busy}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule